// File: doc/BRIEF.md
# Integer ALU with Sign, Zero and Overflow Flags

This block combines two signed data words under a selectable operation (add, subtract, bitwise AND, OR, XOR, or a compare) and presents the result combinationally in the same cycle. Beside the datapath sit three single-bit condition registers: sign, zero and overflow. A downstream branch unit reads them to decide conditional jumps.

When the caller raises `flag_we` with a defined operation, the condition registers capture the new values at the next rising clock edge. At all other times they keep their contents. Arithmetic and bitwise operations derive the condition bits under different rules. For add, subtract and compare, overflow is found by comparing the truncated result against an exact result of double width. For bitwise operations, overflow is always cleared. The compare operation performs a subtraction for its flags only and never asks for its result to be stored.

Top module: `flag_alu`

## Requirements
- R1: With `op_sel` = 0 (add), `result` equals `op_a + op_b` modulo 2^W in the same cycle, and `result_we` is 1.
- R2: With `op_sel` = 1 (subtract), `result` equals `op_a - op_b` modulo 2^W in the same cycle, and `result_we` is 1.
- R3: With `op_sel` = 2, 3 or 4, `result` is the bitwise AND, OR or XOR of the operands respectively, and `result_we` is 1.
- R4: After an arithmetic operation (codes 0, 1, 5) with `flag_we` high, `sign_flag` holds bit W-1 of the W-bit result and `zero_flag` is set exactly when that result is zero. Both are visible after the next rising edge.
- R5: After an arithmetic operation with `flag_we` high, `ovf_flag` is set exactly when the W-bit result, read as signed, differs from the exact signed result computed at 2W bits.
- R6: For subtract and compare, `ovf_flag` is set exactly when the operands' sign bits differ and the result's sign bit differs from that of `op_a`.
- R7: After a bitwise operation with `flag_we` high, `sign_flag` equals result bit W-1, `zero_flag` is set when the result is zero, and `ovf_flag` is 0.
- R8: While `flag_we` is low, all three flags keep their values, whatever the operands and operation.
- R9: With `op_sel` = 5 (compare), `result` shows `op_a - op_b`, the flags follow the subtract rules, and `result_we` is 0.
- R10: While `rst_n` is low, all three flags are 0.
- R11: `op_sel` codes 6 and 7 are undefined: `result` is 0, `result_we` is 0, and the flags do not change even when `flag_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_a | input | W | First operand (signed for arithmetic) |
| op_b | input | W | Second operand |
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 compare |
| flag_we | input | 1 | Flag update strobe |
| result | output | W | Combinational result |
| result_we | output | 1 | Result should be written back |
| sign_flag | output | 1 | Registered sign flag |
| zero_flag | output | 1 | Registered zero flag |
| ovf_flag | output | 1 | Registered overflow flag |

## Verification
The only internal state is the three flag bits. A fault in any of them appears at the ports one clock edge after the strobe that loaded it. A fault in the hold path appears at the first edge where `flag_we` is low and the operands would otherwise change the flags. Faults in the datapath show up on `result` in the same cycle. Overflow faults are reached only with operands near the signed limits, so the tests place operands at 0x7FFFFFFF, 0x80000000 and -1 for both add and subtract. The tests also cover hold, compare and undefined codes while the operands would move every flag.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_CMP = 3'd5,
    OP_RS6 = 3'd6,
    OP_RS7 = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NONE = 2'd3
  } logic_fn_e;

  // Arithmetic class: add, subtract, compare.
  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  endfunction

  function automatic logic op_is_logic(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic_fn_e logic_fn_of(alu_op_e op);
    case (op)
      OP_AND:  return LG_AND;
      OP_OR:   return LG_OR;
      OP_XOR:  return LG_XOR;
      default: return LG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  localparam int WIDE = 2 * W;

  // Exact signed result carried at double width.
  function automatic logic signed [WIDE-1:0] exact_result(
    input logic [W-1:0] x, input logic [W-1:0] y, input logic sub);
    logic signed [WIDE-1:0] xs;
    logic signed [WIDE-1:0] ys;
    xs = $signed({{W{x[W-1]}}, x});
    ys = $signed({{W{y[W-1]}}, y});
    return sub ? (xs - ys) : (xs + ys);
  endfunction

  // Re-widen a truncated word by sign extension.
  function automatic logic signed [WIDE-1:0] widen(input logic [W-1:0] v);
    return $signed({{W{v[W-1]}}, v});
  endfunction

  logic signed [WIDE-1:0] exact_w;

  always_comb begin
    exact_w = exact_result(a, b, do_sub);
    sum     = exact_w[W-1:0];
    ovf     = (widen(exact_w[W-1:0]) != exact_w);
  end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0]               a,
  input  logic [W-1:0]               b,
  input  flag_alu_pkg::logic_fn_e    fn,
  output logic [W-1:0]               y
);
  import flag_alu_pkg::*;

  always_comb begin
    case (fn)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sf_next,
  input  logic zf_next,
  input  logic of_next,
  output logic sf_q,
  output logic zf_q,
  output logic of_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q <= 1'b0;
      zf_q <= 1'b0;
      of_q <= 1'b0;
    end else if (load) begin
      sf_q <= sf_next;
      zf_q <= zf_next;
      of_q <= of_next;
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         sign_flag,
  output logic         zero_flag,
  output logic         ovf_flag
);
  import flag_alu_pkg::*;

  alu_op_e     op;
  logic        is_arith;
  logic        is_logic;
  logic        op_valid;
  logic        want_sub;
  logic        flags_load;
  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic        arith_ovf;
  logic        sf_next;
  logic        zf_next;
  logic        of_next;
  logic_fn_e   lfn;

  always_comb begin
    op       = alu_op_e'(op_sel);
    is_arith = op_is_arith(op);
    is_logic = op_is_logic(op);
    op_valid = is_arith | is_logic;
    want_sub = (op == OP_SUB) || (op == OP_CMP);
    lfn      = logic_fn_of(op);
  end

  flag_alu_arith #(.W(W)) u_arith (
    .a(op_a), .b(op_b), .do_sub(want_sub), .sum(arith_y), .ovf(arith_ovf)
  );

  flag_alu_logic #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .fn(lfn), .y(logic_y)
  );

  always_comb begin
    if (is_arith)      result = arith_y;
    else if (is_logic) result = logic_y;
    else               result = '0;
    result_we  = op_valid && (op != OP_CMP);
    sf_next    = result[W-1];
    zf_next    = (result == '0);
    of_next    = is_arith ? arith_ovf : 1'b0;
    flags_load = flag_we && op_valid;
  end

  flag_alu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .load(flags_load),
    .sf_next(sf_next), .zf_next(zf_next), .of_next(of_next),
    .sf_q(sign_flag), .zf_q(zero_flag), .of_q(ovf_flag)
  );
endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   op_sel,
  input logic         flag_we,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic         sign_flag,
  input logic         zero_flag,
  input logic         ovf_flag
);
  logic valid_op;
  logic logic_op;
  logic subish;
  assign valid_op = (op_sel <= 3'd5);
  assign logic_op = (op_sel == 3'd2) || (op_sel == 3'd3) || (op_sel == 3'd4);
  assign subish   = (op_sel == 3'd1) || (op_sel == 3'd5);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |-> (!sign_flag && !zero_flag && !ovf_flag));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ($stable(sign_flag) && $stable(zero_flag) && $stable(ovf_flag)));

  assert_logic_no_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && logic_op) |=> !ovf_flag);

  assert_sub_sign_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && subish) |=> ovf_flag ==
      (($past(op_a[W-1]) != $past(op_b[W-1])) && ($past(result[W-1]) != $past(op_a[W-1]))));

  assert_zero_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && valid_op) |=> (zero_flag == ($past(result) == '0)));

  assert_sign_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && valid_op) |=> (sign_flag == $past(result[W-1])));

  assert_cmp_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd5) |-> !result_we);

  assert_undef_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_op |-> (!result_we && result == '0));

  assert_undef_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_op |=> ($stable(sign_flag) && $stable(zero_flag) && $stable(ovf_flag)));
endmodule

bind flag_alu flag_alu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
  .flag_we(flag_we), .result(result), .result_we(result_we),
  .sign_flag(sign_flag), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [2:0]  op_sel;
  logic        flag_we;
  logic [31:0] result;
  logic        result_we;
  logic        sign_flag, zero_flag, ovf_flag;

  int n_tests = 0;
  int n_fail  = 0;
  logic e_sf = 1'b0, e_zf = 1'b0, e_of = 1'b0;

  always #2 clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_we(flag_we), .result(result), .result_we(result_we),
    .sign_flag(sign_flag), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Apply one operation, check the combinational outputs and the flags after the edge.
  task automatic run_op(string req, logic [31:0] a, logic [31:0] b, logic [2:0] sel, logic we);
    longint xa, xb, exact;
    logic [31:0] ey;
    logic ewe, n_sf, n_zf, n_of;
    xa = $signed(a);
    xb = $signed(b);
    ewe = 1'b1;
    n_of = 1'b0;
    case (sel)
      3'd0: begin exact = xa + xb; ey = exact[31:0]; n_of = (longint'($signed(ey)) != exact); end
      3'd1: begin exact = xa - xb; ey = exact[31:0]; n_of = (longint'($signed(ey)) != exact); end
      3'd5: begin exact = xa - xb; ey = exact[31:0]; n_of = (longint'($signed(ey)) != exact); ewe = 1'b0; end
      3'd2: ey = a & b;
      3'd3: ey = a | b;
      3'd4: ey = a ^ b;
      default: begin ey = 32'h0; ewe = 1'b0; end
    endcase
    n_sf = ey[31];
    n_zf = (ey == 32'h0);
    @(negedge clk);
    op_a = a; op_b = b; op_sel = sel; flag_we = we;
    #1;
    chk({req, " result"}, result, ey);
    chk({req, " result_we"}, {31'b0, result_we}, {31'b0, ewe});
    if (we && sel <= 3'd5) begin e_sf = n_sf; e_zf = n_zf; e_of = n_of; end
    @(posedge clk);
    #1;
    chk({req, " flags sf/zf/of"}, {29'b0, sign_flag, zero_flag, ovf_flag}, {29'b0, e_sf, e_zf, e_of});
    flag_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset flags", {29'b0, sign_flag, zero_flag, ovf_flag}, 32'h0);
  endtask

  task automatic t_add();
    run_op("R1 R4 add small", 32'd5, 32'd7, 3'd0, 1'b1);
    run_op("R1 R4 add to zero", 32'hFFFF_FFFF, 32'd1, 3'd0, 1'b1);
    run_op("R5 add pos overflow", 32'h7FFF_FFFF, 32'd1, 3'd0, 1'b1);
    run_op("R5 add neg overflow", 32'h8000_0000, 32'h8000_0000, 3'd0, 1'b1);
    run_op("R4 add negative", 32'hFFFF_FFF0, 32'd3, 3'd0, 1'b1);
  endtask

  task automatic t_sub();
    run_op("R2 R4 sub equal", 32'd9, 32'd9, 3'd1, 1'b1);
    run_op("R6 sub min minus one", 32'h8000_0000, 32'd1, 3'd1, 1'b1);
    run_op("R6 sub zero minus min", 32'h0, 32'h8000_0000, 3'd1, 1'b1);
    run_op("R5 sub max minus neg", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'd1, 1'b1);
    run_op("R2 sub negative", 32'd3, 32'd10, 3'd1, 1'b1);
  endtask

  task automatic t_logic();
    run_op("R5 prime ovf", 32'h7FFF_FFFF, 32'd1, 3'd0, 1'b1);
    run_op("R3 R7 and clears ovf", 32'hF0F0_0000, 32'h8F00_0000, 3'd2, 1'b1);
    run_op("R3 R7 or", 32'h0000_00F0, 32'h0000_000F, 3'd3, 1'b1);
    run_op("R3 R7 xor to zero", 32'hA5A5_A5A5, 32'hA5A5_A5A5, 3'd4, 1'b1);
    run_op("R7 and zero", 32'h1234_0000, 32'h0000_4321, 3'd2, 1'b1);
  endtask

  task automatic t_hold();
    run_op("R8 set flags", 32'h7FFF_FFFF, 32'd1, 3'd0, 1'b1);
    run_op("R8 hold on add", 32'd1, 32'hFFFF_FFFF, 3'd0, 1'b0);
    run_op("R8 hold on xor", 32'h0, 32'h0, 3'd4, 1'b0);
    run_op("R8 hold on sub", 32'd4, 32'd1, 3'd1, 1'b0);
  endtask

  task automatic t_cmp();
    run_op("R9 cmp equal", 32'd42, 32'd42, 3'd5, 1'b1);
    run_op("R9 R6 cmp overflow", 32'h8000_0000, 32'd1, 3'd5, 1'b1);
    run_op("R9 cmp less", 32'd1, 32'd2, 3'd5, 1'b1);
  endtask

  task automatic t_undef();
    run_op("R11 prime", 32'h8000_0000, 32'h8000_0000, 3'd0, 1'b1);
    run_op("R11 code 6", 32'h0, 32'h0, 3'd6, 1'b1);
    run_op("R11 code 7", 32'h1, 32'h2, 3'd7, 1'b1);
  endtask

  initial begin
    #100000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; op_sel = 3'd0; flag_we = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_logic();
    t_hold();
    t_cmp();
    t_undef();
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule